// File: doc/BRIEF.md
# Tiled Rendering Address Translator

This block sits between a pixel pipeline and the memory system. It turns a buffer selector and an x/y pixel coordinate into a physical byte address. Each render surface (colour, depth/stencil, texture, overlay or window clip) is cut into square tiles of 128 by 128 pixels, four bytes per pixel. Each tile lives in its own 64 KB block, which may sit anywhere in physical memory. A small table holds the physical base of every tile. A descriptor for each buffer says where that buffer's tiles start in the table, how many tiles make one row, and how many tile rows there are.

This table serves rendering only and is not tied to any process address space. Rendering never waits for a missing page, so every entry must point at memory that is already resident. A lookup that falls outside the buffer, or that lands on an entry marked not present, comes back as a fault and produces no access. Software moves rendering to another surface, for example an off-screen one, by loading that surface's descriptor and tile bases through the write port. Lookups are pipelined: one request is accepted per cycle and each result appears two cycles later, in request order.

Top module: `tile_xlat`

## Requirements
- R1: After reset, accValid, accFault, accAddr and faultCode are all zero. Every descriptor reads as zero, so any lookup faults with the range code, and every table entry reads as not present.
- R2: A request sampled with reqValid high at clock edge N produces exactly one result, visible after edge N+2. One request may be accepted every cycle, and results leave in request order.
- R3: For a mapped lookup, accAddr is the tile base in bits 31:16 and the in-tile byte offset ((y mod 128)*128 + (x mod 128))*4 in bits 15:0.
- R4: The table entry used is start + (y div 128)*pitch + (x div 128), where start, pitch and height come from the descriptor of reqBuf.
- R5: A lookup faults with faultCode 1 (range) when any of these holds: reqBuf is 5 or more, x div 128 is at least pitch, y div 128 is at least height, or the computed entry index is at least 64.
- R6: A lookup that passes the range test but reaches an entry whose present bit is 0 faults with faultCode 2 (unmapped). The range fault takes precedence. faultCode 3 never occurs.
- R7: While wrEn is high, the write port updates state at the clock edge. With wrKind=0 it writes table entry wrAddr: wrData bit 16 is the present bit and bits 15:0 are the tile base. With wrKind=1 it writes the descriptor of buffer wrAddr: bits 5:0 are start, bits 11:6 are pitch in tiles, bits 17:12 are height in tiles. Lookups issued in later cycles use the new values, so a surface switch and the invalidation of an entry both take effect at once.
- R8: accValid and accFault are never both high. On a fault, accValid is low and accAddr is zero, so the access is suppressed.
- R9: A cycle whose request was not valid two edges earlier shows accValid and accFault both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A lookup request is present this cycle |
| reqBuf | input | 3 | Buffer selector, 0 to 4 in use |
| reqX | input | 12 | Pixel column |
| reqY | input | 12 | Pixel row |
| wrEn | input | 1 | Write strobe for the table or a descriptor |
| wrKind | input | 1 | 0 writes a table entry, 1 writes a buffer descriptor |
| wrAddr | input | 6 | Entry index or buffer number |
| wrData | input | 18 | Entry or descriptor fields |
| accValid | output | 1 | A translated access is issued |
| accFault | output | 1 | The lookup faulted and no access is issued |
| accAddr | output | 32 | Physical byte address, zero on a fault |
| faultCode | output | 2 | 0 none, 1 range, 2 unmapped |

## Verification
The lookups probe the pixels at the corners of a tile: 0 and 127 within one tile, and the first pixel of the next tile. These separate the offset arithmetic from the tile index, and a swapped or mis-scaled axis shows up in the upper or the lower address half. Requests are sent back to back and with gaps. This exposes latency or ordering slips, and a result that is dropped or duplicated. Faults are provoked one cause at a time: column past pitch, row past height, index past the table end, an unused buffer number, and an entry marked not present. The order of the checks then shows whether the range fault takes precedence. A retarget and an invalidation follow, then a run of idle cycles, which must stay silent.

// File: rtl/tile_xlat_pkg.sv
package tile_xlat_pkg;

  // Strobes the control sends to the datapath each cycle
  typedef struct packed {
    logic s1Load;   // capture a new request into stage one
    logic s2Load;   // stage one holds a request, produce its result
    logic wrEntry;  // write a tile table entry
    logic wrDesc;   // write a buffer descriptor
  } xlat_strobe_t;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_RANGE    = 2'd1,
    FLT_UNMAPPED = 2'd2
  } fault_e;

endpackage

// File: rtl/tile_xlat_ctrl.sv
module tile_xlat_ctrl
  import tile_xlat_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         wrEn,
  input  logic         wrKind,
  input  logic         s2Fault,
  output xlat_strobe_t strb,
  output logic         accValid,
  output logic         accFault
);

  logic s1Valid;
  logic s2Valid;

  // Pipeline occupancy, one bit per stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
    end else begin
      s1Valid <= reqValid;
      s2Valid <= s1Valid;
    end
  end

  always_comb begin
    strb.s1Load  = reqValid;
    strb.s2Load  = s1Valid;
    strb.wrEntry = wrEn & ~wrKind;
    strb.wrDesc  = wrEn & wrKind;
  end

  assign accValid = s2Valid & ~s2Fault;
  assign accFault = s2Valid & s2Fault;

  // R2: every result traces back to a request two edges earlier
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accValid || accFault) |-> $past(reqValid, 2));

  // R9: no request two edges ago means nothing comes out now
  assert_silent_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(reqValid, 2) |-> !(accValid || accFault));

endmodule

// File: rtl/tile_xlat_dp.sv
module tile_xlat_dp
  import tile_xlat_pkg::*;
#(
  parameter int NUM_BUFS  = 5,
  parameter int BUF_W     = 3,
  parameter int COORD_W   = 12,
  parameter int TILE_LOG2 = 7,
  parameter int PIX_LOG2  = 2,
  parameter int ADDR_W    = 32,
  parameter int TBL_DEPTH = 64,
  localparam int TIDX_W   = $clog2(TBL_DEPTH),
  localparam int PAGE_W   = 2 * TILE_LOG2 + PIX_LOG2,
  localparam int BASE_W   = ADDR_W - PAGE_W,
  localparam int WR_W     = (3 * TIDX_W > BASE_W + 1) ? 3 * TIDX_W : BASE_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  xlat_strobe_t        strb,
  input  logic [BUF_W-1:0]    reqBuf,
  input  logic [COORD_W-1:0]  reqX,
  input  logic [COORD_W-1:0]  reqY,
  input  logic [TIDX_W-1:0]   wrAddr,
  input  logic [WR_W-1:0]     wrData,
  output logic                s2Fault,
  output logic [ADDR_W-1:0]   accAddr,
  output fault_e              faultCode
);

  localparam int TC_W  = COORD_W - TILE_LOG2;
  localparam int SUM_W = TC_W + TIDX_W + 2;

  // ---------------------------------------------------------------
  // Buffer descriptors, one register set per buffer
  // ---------------------------------------------------------------
  logic [NUM_BUFS*TIDX_W-1:0] startFlat;
  logic [NUM_BUFS*TIDX_W-1:0] pitchFlat;
  logic [NUM_BUFS*TIDX_W-1:0] heightFlat;

  for (genvar g = 0; g < NUM_BUFS; g++) begin : gDesc
    logic [TIDX_W-1:0] dStart;
    logic [TIDX_W-1:0] dPitch;
    logic [TIDX_W-1:0] dHeight;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dStart  <= '0;
        dPitch  <= '0;
        dHeight <= '0;
      end else if (strb.wrDesc && wrAddr == TIDX_W'(g)) begin
        dStart  <= wrData[TIDX_W-1:0];
        dPitch  <= wrData[2*TIDX_W-1:TIDX_W];
        dHeight <= wrData[3*TIDX_W-1:2*TIDX_W];
      end
    end

    assign startFlat[g*TIDX_W +: TIDX_W]  = dStart;
    assign pitchFlat[g*TIDX_W +: TIDX_W]  = dPitch;
    assign heightFlat[g*TIDX_W +: TIDX_W] = dHeight;
  end

  // ---------------------------------------------------------------
  // Stage one: tile coordinates, table index, range test, offset
  // ---------------------------------------------------------------
  logic                bufOk;
  logic [BUF_W-1:0]    bufIdx;
  logic [TIDX_W-1:0]   selStart;
  logic [TIDX_W-1:0]   selPitch;
  logic [TIDX_W-1:0]   selHeight;
  logic [TC_W-1:0]     tileX;
  logic [TC_W-1:0]     tileY;
  logic [SUM_W-1:0]    tileSum;
  logic                rangeHit;
  logic [PAGE_W-1:0]   pageOff;

  always_comb begin
    bufOk     = int'(reqBuf) < NUM_BUFS;
    bufIdx    = bufOk ? reqBuf : '0;
    selStart  = startFlat[bufIdx*TIDX_W +: TIDX_W];
    selPitch  = pitchFlat[bufIdx*TIDX_W +: TIDX_W];
    selHeight = heightFlat[bufIdx*TIDX_W +: TIDX_W];
    tileX     = reqX[COORD_W-1:TILE_LOG2];
    tileY     = reqY[COORD_W-1:TILE_LOG2];
    tileSum   = SUM_W'(selStart) + SUM_W'(tileY) * SUM_W'(selPitch) + SUM_W'(tileX);
    rangeHit  = !bufOk
             || (SUM_W'(tileX) >= SUM_W'(selPitch))
             || (SUM_W'(tileY) >= SUM_W'(selHeight))
             || (tileSum >= SUM_W'(TBL_DEPTH));
    pageOff   = {reqY[TILE_LOG2-1:0], reqX[TILE_LOG2-1:0], {PIX_LOG2{1'b0}}};
  end

  logic [TIDX_W-1:0] s1Idx;
  logic              s1Range;
  logic [PAGE_W-1:0] s1Off;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Idx   <= '0;
      s1Range <= 1'b0;
      s1Off   <= '0;
    end else if (strb.s1Load) begin
      s1Idx   <= tileSum[TIDX_W-1:0];
      s1Range <= rangeHit;
      s1Off   <= pageOff;
    end
  end

  // ---------------------------------------------------------------
  // Tile table: present bit on top, physical tile base below
  // ---------------------------------------------------------------
  logic [BASE_W:0] tbl [TBL_DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TBL_DEPTH; i++) tbl[i] <= '0;
    end else if (strb.wrEntry) begin
      tbl[wrAddr] <= wrData[BASE_W:0];
    end
  end

  // ---------------------------------------------------------------
  // Stage two: table read, fault choice, address assembly
  // ---------------------------------------------------------------
  logic [BASE_W:0] ent;
  assign ent = tbl[s1Idx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accAddr   <= '0;
      faultCode <= FLT_NONE;
    end else if (strb.s2Load) begin
      if (s1Range) begin
        accAddr   <= '0;
        faultCode <= FLT_RANGE;
      end else if (!ent[BASE_W]) begin
        accAddr   <= '0;
        faultCode <= FLT_UNMAPPED;
      end else begin
        accAddr   <= {ent[BASE_W-1:0], s1Off};
        faultCode <= FLT_NONE;
      end
    end else begin
      accAddr   <= '0;
      faultCode <= FLT_NONE;
    end
  end

  assign s2Fault = (faultCode != FLT_NONE);

  // R5: a buffer number past the last one is a range fault
  assert_badbuf_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.s1Load && int'(reqBuf) >= NUM_BUFS) |=> s1Range);

  // R6: only the three defined codes appear
  assert_code_legal_R6: assert property (@(posedge clk) disable iff (!rstN)
    faultCode != 2'b11);

  // R8: a faulted lookup carries no address
  assert_fault_noaddr_R8: assert property (@(posedge clk) disable iff (!rstN)
    (faultCode != FLT_NONE) |-> (accAddr == '0));

  // R7: an entry write lands in the addressed slot
  assert_tblwrite_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEntry |=> (tbl[$past(wrAddr)] == $past(wrData[BASE_W:0])));

endmodule

// File: rtl/tile_xlat.sv
module tile_xlat
  import tile_xlat_pkg::*;
#(
  parameter int NUM_BUFS  = 5,
  parameter int BUF_W     = 3,
  parameter int COORD_W   = 12,
  parameter int TILE_LOG2 = 7,
  parameter int PIX_LOG2  = 2,
  parameter int ADDR_W    = 32,
  parameter int TBL_DEPTH = 64,
  localparam int TIDX_W   = $clog2(TBL_DEPTH),
  localparam int PAGE_W   = 2 * TILE_LOG2 + PIX_LOG2,
  localparam int BASE_W   = ADDR_W - PAGE_W,
  localparam int WR_W     = (3 * TIDX_W > BASE_W + 1) ? 3 * TIDX_W : BASE_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [BUF_W-1:0]   reqBuf,
  input  logic [COORD_W-1:0] reqX,
  input  logic [COORD_W-1:0] reqY,
  input  logic               wrEn,
  input  logic               wrKind,
  input  logic [TIDX_W-1:0]  wrAddr,
  input  logic [WR_W-1:0]    wrData,
  output logic               accValid,
  output logic               accFault,
  output logic [ADDR_W-1:0]  accAddr,
  output logic [1:0]         faultCode
);

  xlat_strobe_t strb;
  logic         s2Fault;
  fault_e       fltCode;

  tile_xlat_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .wrEn     (wrEn),
    .wrKind   (wrKind),
    .s2Fault  (s2Fault),
    .strb     (strb),
    .accValid (accValid),
    .accFault (accFault)
  );

  tile_xlat_dp #(
    .NUM_BUFS  (NUM_BUFS),
    .BUF_W     (BUF_W),
    .COORD_W   (COORD_W),
    .TILE_LOG2 (TILE_LOG2),
    .PIX_LOG2  (PIX_LOG2),
    .ADDR_W    (ADDR_W),
    .TBL_DEPTH (TBL_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqBuf    (reqBuf),
    .reqX      (reqX),
    .reqY      (reqY),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .s2Fault   (s2Fault),
    .accAddr   (accAddr),
    .faultCode (fltCode)
  );

  assign faultCode = fltCode;

endmodule

// File: tb/tile_xlat_bench.sv
module tile_xlat_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [2:0]  reqBuf;
  logic [11:0] reqX;
  logic [11:0] reqY;
  logic        wrEn;
  logic        wrKind;
  logic [5:0]  wrAddr;
  logic [17:0] wrData;
  logic        accValid;
  logic        accFault;
  logic [31:0] accAddr;
  logic [1:0]  faultCode;

  always #10 clk = ~clk;

  tile_xlat u_tile_xlat (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqBuf    (reqBuf),
    .reqX      (reqX),
    .reqY      (reqY),
    .wrEn      (wrEn),
    .wrKind    (wrKind),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .accValid  (accValid),
    .accFault  (accFault),
    .accAddr   (accAddr),
    .faultCode (faultCode)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Reference state kept from the requirements
  logic        mPres [64];
  logic [15:0] mBase [64];
  int          mStart [64];
  int          mPitch [64];
  int          mHeight [64];

  typedef struct {
    int          issue;
    logic [1:0]  code;
    logic [31:0] addr;
    string       tag;
  } exp_t;

  exp_t sbq[$];

  function automatic void predict(input int b, input int x, input int y,
                                  output logic [1:0] code, output logic [31:0] addr);
    int tx, ty, idx, off;
    tx  = x / 128;
    ty  = y / 128;
    off = ((y % 128) * 128 + (x % 128)) * 4;
    code = 2'd0;
    addr = 32'd0;
    if (b >= 5) begin
      code = 2'd1;
    end else begin
      idx = mStart[b] + ty * mPitch[b] + tx;
      if (tx >= mPitch[b] || ty >= mHeight[b] || idx >= 64) code = 2'd1;
      else if (!mPres[idx]) code = 2'd2;
      else addr = {mBase[idx], off[15:0]};
    end
  endfunction

  // Monitor: pops the scoreboard whenever a result appears
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (accValid || accFault) begin
        if (sbq.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R9 unexpected result: valid=%0b fault=%0b addr=%h, expected none",
                   accValid, accFault, accAddr);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          checks++;
          if (accValid != (e.code == 2'd0) || accFault != (e.code != 2'd0) ||
              faultCode != e.code || accAddr != e.addr || cyc != e.issue + 2) begin
            errors++;
            $display("FAIL %s: valid=%0b fault=%0b code=%0d addr=%h cyc=%0d, expected code=%0d addr=%h cyc=%0d",
                     e.tag, accValid, accFault, faultCode, accAddr, cyc,
                     e.code, e.addr, e.issue + 2);
          end
        end
      end
    end
  end

  task automatic drive_req(input int b, input int x, input int y, input string tag);
    exp_t e;
    @(negedge clk);
    reqValid = 1'b1;
    reqBuf   = b[2:0];
    reqX     = x[11:0];
    reqY     = y[11:0];
    wrEn     = 1'b0;
    predict(b, x, y, e.code, e.addr);
    e.issue = cyc;
    e.tag   = tag;
    sbq.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      reqValid = 1'b0;
      wrEn     = 1'b0;
    end
  endtask

  task automatic wr_entry(input int i, input bit pres, input int base);
    @(negedge clk);
    reqValid = 1'b0;
    wrEn     = 1'b1;
    wrKind   = 1'b0;
    wrAddr   = i[5:0];
    wrData   = {1'b0, pres, base[15:0]};
    mPres[i] = pres;
    mBase[i] = base[15:0];
  endtask

  task automatic wr_desc(input int b, input int st, input int p, input int h);
    @(negedge clk);
    reqValid   = 1'b0;
    wrEn       = 1'b1;
    wrKind     = 1'b1;
    wrAddr     = b[5:0];
    wrData     = {h[5:0], p[5:0], st[5:0]};
    mStart[b]  = st;
    mPitch[b]  = p;
    mHeight[b] = h;
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mPres[i] = 1'b0; mBase[i] = '0;
      mStart[i] = 0; mPitch[i] = 0; mHeight[i] = 0;
    end
    rstN = 1'b0; reqValid = 1'b0; reqBuf = '0; reqX = '0; reqY = '0;
    wrEn = 1'b0; wrKind = 1'b0; wrAddr = '0; wrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state at the ports
    @(negedge clk);
    checks++;
    if (accValid || accFault || accAddr != 0 || faultCode != 0) begin
      errors++;
      $display("FAIL R1 reset outputs: valid=%0b fault=%0b addr=%h code=%0d, expected all zero",
               accValid, accFault, accAddr, faultCode);
    end
    drive_req(0, 5, 5, "R1 lookup after reset");
    idle(3);

    // Colour surface: 4 x 3 tiles at entries 0..11, entry 7 left absent
    wr_desc(0, 0, 4, 3);
    for (int i = 0; i < 12; i++) begin
      if (i != 7) wr_entry(i, 1'b1, 16'h4000 + i * 307);
    end
    wr_entry(7, 1'b0, 16'h7777);

    // Back-to-back lookups, R2 ordering and latency throughout
    drive_req(0, 0, 0, "R3 tile origin");
    drive_req(0, 127, 127, "R3 last pixel of tile");
    drive_req(0, 128, 0, "R4 next tile in row");
    drive_req(0, 200, 300, "R4 interior tile");
    drive_req(0, 511, 383, "R4 last tile");
    drive_req(0, 512, 0, "R5 column past pitch");
    drive_req(0, 0, 384, "R5 row past height");
    drive_req(6, 0, 0, "R5 buffer number unused");
    drive_req(0, 3 * 128 + 1, 128 + 2, "R6 entry not present");
    drive_req(0, 10, 10, "R2 back to back");
    idle(1);
    drive_req(0, 300, 10, "R2 after gap");
    idle(3);

    // Texture surface near the table end
    wr_desc(3, 60, 2, 3);
    for (int i = 60; i < 64; i++) wr_entry(i, 1'b1, 16'h9000 + i * 19);
    drive_req(3, 129, 129, "R4 table end entry");
    drive_req(3, 0, 256, "R5 index past table");
    drive_req(5, 0, 0, "R5 buffer five");
    drive_req(3, 4095, 0, "R5 far column");
    idle(3);

    // Retarget colour to entries 20..23 and invalidate entry 1
    wr_desc(0, 20, 2, 2);
    for (int i = 20; i < 24; i++) wr_entry(i, 1'b1, 16'h2000 + i * 1031);
    wr_desc(1, 0, 4, 3);
    wr_entry(1, 1'b0, 16'h0);
    drive_req(0, 0, 0, "R7 retargeted origin");
    drive_req(0, 130, 130, "R7 retargeted last tile");
    drive_req(0, 300, 0, "R7 old extent now range");
    drive_req(1, 130, 5, "R7 invalidated entry");
    drive_req(1, 0, 0, "R8 mapped via other buffer");
    idle(4);

    // R9: idle cycles stay silent
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      checks++;
      if (accValid || accFault) begin
        errors++;
        $display("FAIL R9 idle cycle: valid=%0b fault=%0b, expected 0 0", accValid, accFault);
      end
    end

    checks++;
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL R2 results missing: %0d pending, expected 0", sbq.size());
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule